// File: doc/BRIEF.md
# Shiftable Bus Register with Magnitude Comparator

This block holds one word that lives beside a shared, bidirectional data bus. Two select lines choose what happens at each rising clock edge. The word can take a value from the bus in parallel, or shift one bit in from a serial input at the low end, with the top bit leaving on a serial output. It can also keep its value, or drive its value back onto the bus. The bus appears as three separate signals: an input value, an output value and an output enable.

A comparator runs all the time. It checks the stored word against the value the bus currently carries, and it raises one of three active-high flags: equal, stored word greater, or stored word smaller. A mode pin chooses between unsigned and two's-complement comparison. A status enable pin forces all three flags low when it is deasserted.

Link inputs and outputs let several slices be chained to compare longer words. The lowest slice ties its link inputs to "equal". Each higher slice takes the link flags of the slice just below it. Only the top slice runs in signed mode.

Top module: `regcmp_slice`

## Requirements
- R1: An active-high asynchronous reset clears the stored word to zero at once, without waiting for a clock edge.
- R2: With select 2'b10 (load), the stored word takes the value of `bus_in` at the rising clock edge.
- R3: With select 2'b01 (shift), the stored word becomes {word[W-2:0], `ser_in`} at the rising edge. `ser_out` always shows the word's most significant bit.
- R4: With select 2'b00 (hold), the stored word keeps its value. Changes on `bus_in` and `ser_in` have no effect on it.
- R5: With select 2'b11 (read-out), `bus_oe` is 1 and `bus_out` shows the stored word, which keeps its value. With any other select, `bus_oe` is 0.
- R6: With `signed_mode` 0, the comparison treats both words as unsigned numbers. When the link inputs show only equal, exactly one of `eq_o`, `gt_o` and `lt_o` is 1.
- R7: With `signed_mode` 1, the comparison treats both words as two's-complement numbers. For example, 0x80 is smaller than 0x7F.
- R8: When `stat_en` is 0, `eq_o`, `gt_o` and `lt_o` are all 0, whatever the inputs.
- R9: When the stored word differs from the compared bus value, the slice's own result drives the flags and the link inputs are ignored. When the two are equal, the flags repeat `link_eq_in`, `link_gt_in` and `link_lt_in`.
- R10: During read-out, the comparator sees the bus carrying the stored word. The flags therefore repeat the link inputs, so a lowest slice (links tied to equal) shows `eq_o` 1, `gt_o` 0 and `lt_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| sel | input | 2 | Operation: 00 hold, 01 shift, 10 load, 11 read-out |
| ser_in | input | 1 | Serial bit entering at the LSB |
| ser_out | output | 1 | Serial bit leaving from the MSB |
| bus_in | input | W | Value currently on the bus |
| bus_out | output | W | Stored word presented to the bus |
| bus_oe | output | 1 | Bus output enable, high in read-out |
| signed_mode | input | 1 | 1: two's-complement compare, 0: unsigned |
| stat_en | input | 1 | Flag enable; 0 forces all flags low |
| link_eq_in | input | 1 | Equal result from the less significant slice |
| link_gt_in | input | 1 | Greater result from the less significant slice |
| link_lt_in | input | 1 | Less result from the less significant slice |
| eq_o | output | 1 | Stored word equals bus (after linking) |
| gt_o | output | 1 | Stored word greater than bus (after linking) |
| lt_o | output | 1 | Stored word less than bus (after linking) |

## Verification
The assertion that the three flags are mutually exclusive assumes the link inputs never carry more than one active flag. A real cascade upholds this, and the bench drives only zero-hot or one-hot link combinations. Select is assumed stable between edges. The stimulus changes it only on the falling edge, so every registered check compares against the select that was sampled. The compare sweep keeps the links tied to equal and the status enable high, except in the separate link and gating checks. This keeps each sweep result purely a function of the two words and the mode.

// File: rtl/regcmp_pkg.sv
package regcmp_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_SHIFT = 2'b01,
    OP_LOAD  = 2'b10,
    OP_READ  = 2'b11
  } op_e;

  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } rel_t;
endpackage

// File: rtl/regcmp_store.sv
module regcmp_store
  import regcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  op_e          op,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (op)
        OP_SHIFT: q <= {q[W-2:0], ser_in};
        OP_LOAD:  q <= par_in;
        default:  q <= q;
      endcase
    end
  end

  // R2: a load captures the bus value sampled at the edge
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (q == $past(par_in)));

  // R3: a shift moves the word up by one and takes the serial bit at bit 0
  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT) |=> (q[0] == $past(ser_in) && q[W-1:1] == $past(q[W-2:0])));

  // R4 and R5: hold and read-out leave the word untouched
  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD || op == OP_READ) |=> $stable(q));
endmodule

// File: rtl/regcmp_compare.sv
module regcmp_compare
  import regcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         signed_mode,
  input  rel_t         link,
  output rel_t         rel
);
  logic [W-1:0] a_key, b_key;
  logic         own_eq, own_gt;

  // Flipping the sign bit maps two's-complement order onto unsigned order.
  always_comb begin
    a_key = {a[W-1] ^ signed_mode, a[W-2:0]};
    b_key = {b[W-1] ^ signed_mode, b[W-2:0]};
    own_eq = (a_key == b_key);
    own_gt = (a_key > b_key);
    if (own_eq) begin
      rel = link;
    end else begin
      rel.eq = 1'b0;
      rel.gt = own_gt;
      rel.lt = ~own_gt;
    end
  end
endmodule

// File: rtl/regcmp_slice.sv
module regcmp_slice
  import regcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   sel,
  input  logic         ser_in,
  output logic         ser_out,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  input  logic         signed_mode,
  input  logic         stat_en,
  input  logic         link_eq_in,
  input  logic         link_gt_in,
  input  logic         link_lt_in,
  output logic         eq_o,
  output logic         gt_o,
  output logic         lt_o
);
  op_e          op;
  logic [W-1:0] word;
  logic [W-1:0] bus_seen;
  rel_t         link_rel, result;

  assign op = op_e'(sel);

  regcmp_store #(.W(W)) store_i (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .ser_in (ser_in),
    .par_in (bus_in),
    .q      (word)
  );

  // While driving, the resolved bus carries the stored word itself.
  assign bus_oe   = (op == OP_READ);
  assign bus_out  = word;
  assign ser_out  = word[W-1];
  assign bus_seen = bus_oe ? word : bus_in;
  assign link_rel = '{eq: link_eq_in, gt: link_gt_in, lt: link_lt_in};

  regcmp_compare #(.W(W)) cmp_i (
    .a           (word),
    .b           (bus_seen),
    .signed_mode (signed_mode),
    .link        (link_rel),
    .rel         (result)
  );

  assign eq_o = stat_en & result.eq;
  assign gt_o = stat_en & result.gt;
  assign lt_o = stat_en & result.lt;

  // R8: gated flags stay off
  p_gate_off_r8: assert property (@(posedge clk) disable iff (rst)
    !stat_en |-> !(eq_o || gt_o || lt_o));

  // R6: flags are exclusive whenever the links are
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({link_eq_in, link_gt_in, link_lt_in}) |-> $onehot0({eq_o, gt_o, lt_o}));

  // R10: read-out compares the word with itself, so links pass through
  p_read_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && stat_en) |-> (eq_o == link_eq_in && gt_o == link_gt_in && lt_o == link_lt_in));

  // R5: the presented word does not move across a read-out edge
  p_read_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b11) |=> $stable(bus_out));

  // R7: in signed mode a differing sign bit alone decides the order
  p_sign_split_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_en && signed_mode && !bus_oe && (bus_out[W-1] != bus_in[W-1]))
      |-> (gt_o == bus_in[W-1] && lt_o == bus_out[W-1]));
endmodule

// File: tb/regcmp_slice_tb.sv
module regcmp_slice_tb_top;
  localparam int W = 8;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst = 1'b0;
  logic [1:0] sel = 2'b00;
  logic ser_in = 1'b0, signed_mode = 1'b0, stat_en = 1'b1;
  logic link_eq_in = 1'b1, link_gt_in = 1'b0, link_lt_in = 1'b0;
  logic [W-1:0] bus_in = '0;
  logic ser_out, bus_oe, eq_o, gt_o, lt_o;
  logic [W-1:0] bus_out;

  int n_run = 0, n_fail = 0;
  logic [W-1:0] model = '0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  regcmp_slice #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .sel(sel), .ser_in(ser_in), .ser_out(ser_out),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .signed_mode(signed_mode), .stat_en(stat_en),
    .link_eq_in(link_eq_in), .link_gt_in(link_gt_in), .link_lt_in(link_lt_in),
    .eq_o(eq_o), .gt_o(gt_o), .lt_o(lt_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clock_op(input logic [1:0] s, input logic [W-1:0] b, input logic si);
    @(negedge clk);
    sel = s; bus_in = b; ser_in = si;
    @(posedge clk);
    #1;
  endtask

  task automatic check_flags(input string req, input logic [2:0] exp);
    #1;
    check(req, int'({eq_o, gt_o, lt_o}), int'(exp));
  endtask

  function automatic logic [2:0] expect_rel(input logic [W-1:0] a, input logic [W-1:0] b, input logic sm);
    int ia, ib;
    ia = sm ? int'($signed(a)) : int'(a);
    ib = sm ? int'($signed(b)) : int'(b);
    if (ia == ib) return 3'b100;
    return (ia > ib) ? 3'b010 : 3'b001;
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    #(PERIOD * 2);
    check("R1 reset word", int'(bus_out), 0);
    check("R5 no drive in hold", int'(bus_oe), 0);
    @(negedge clk); rst = 1'b0;

    // R2 parallel load
    clock_op(2'b10, 8'hA5, 1'b0); model = 8'hA5;
    check("R2 load", int'(bus_out), int'(model));
    clock_op(2'b10, 8'h3C, 1'b1); model = 8'h3C;
    check("R2 load", int'(bus_out), int'(model));

    // R3 serial shift, LSB in, MSB out
    for (int i = 0; i < 10; i++) begin
      logic bit_in;
      bit_in = logic'((i * 3 + 1) % 2);
      clock_op(2'b01, 8'hFF, bit_in);
      model = {model[W-2:0], bit_in};
      check("R3 shift word", int'(bus_out), int'(model));
      check("R3 serial out", int'(ser_out), int'(model[W-1]));
    end

    // R4 hold ignores bus and serial input
    for (int i = 0; i < 4; i++) begin
      clock_op(2'b00, 8'(i * 61 + 7), logic'(i % 2));
      check("R4 hold", int'(bus_out), int'(model));
    end

    // R5 and R10 read-out
    clock_op(2'b10, 8'h5A, 1'b0); model = 8'h5A;
    @(negedge clk); sel = 2'b11; bus_in = 8'h00;
    #1;
    check("R5 oe in read", int'(bus_oe), 1);
    check("R5 read value", int'(bus_out), int'(model));
    check_flags("R10 read eq", 3'b100);
    @(posedge clk); #1;
    check("R5 read keeps word", int'(bus_out), int'(model));
    link_eq_in = 1'b0; link_gt_in = 1'b1;
    check_flags("R10 read passes link", 3'b010);
    link_eq_in = 1'b1; link_gt_in = 1'b0;
    @(negedge clk); sel = 2'b00;
    #1;
    check("R5 oe off", int'(bus_oe), 0);

    // R6 / R7 compare sweeps over many words and every bus value
    for (int m = 0; m < 2; m++) begin
      signed_mode = logic'(m);
      for (int r = 0; r < 258; r += 5) begin
        logic [W-1:0] rv;
        rv = (r == 255) ? 8'h80 : (r == 250) ? 8'h7F : 8'(r);
        clock_op(2'b10, rv, 1'b0);
        @(negedge clk); sel = 2'b00;
        for (int b = 0; b < 256; b++) begin
          bus_in = 8'(b);
          check_flags(m ? "R7 signed compare" : "R6 unsigned compare",
                      expect_rel(rv, 8'(b), logic'(m)));
        end
      end
    end

    // R7 key corner: 0x80 against 0x7F
    clock_op(2'b10, 8'h80, 1'b0);
    @(negedge clk); sel = 2'b00; bus_in = 8'h7F;
    signed_mode = 1'b0; check_flags("R6 0x80 vs 0x7F unsigned", 3'b010);
    signed_mode = 1'b1; check_flags("R7 0x80 vs 0x7F signed", 3'b001);

    // R8 status gating
    stat_en = 1'b0;
    bus_in = 8'h7F; check_flags("R8 off lt", 3'b000);
    bus_in = 8'h80; check_flags("R8 off eq", 3'b000);
    signed_mode = 1'b0; bus_in = 8'h00; check_flags("R8 off gt", 3'b000);
    stat_en = 1'b1;

    // R9 cascade linking
    bus_in = 8'h80;
    link_eq_in = 1'b0; link_gt_in = 1'b1; link_lt_in = 1'b0;
    check_flags("R9 equal passes gt", 3'b010);
    link_gt_in = 1'b0; link_lt_in = 1'b1;
    check_flags("R9 equal passes lt", 3'b001);
    bus_in = 8'h10;
    check_flags("R9 own gt wins", 3'b010);
    bus_in = 8'hF0; link_lt_in = 1'b0; link_gt_in = 1'b1;
    check_flags("R9 own lt wins", 3'b001);
    link_eq_in = 1'b1; link_gt_in = 1'b0; link_lt_in = 1'b0;

    // R1 asynchronous reset between edges
    @(negedge clk); #2;
    rst = 1'b1; #1;
    check("R1 async clear", int'(bus_out), 0);
    @(negedge clk); rst = 1'b0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule